// File: doc/BRIEF.md
# SRAM strobe timing protocol checker

This block is a passive monitor that sits beside an asynchronous static-RAM port. A fast reference clock samples the active-low chip select, output enable and write enable, the address bus, the write-data bus and the host's data-bus drive enable. The monitor builds its timing from successive samples. It detects strobe and bus edges by comparing each sample with the one before. It then measures the length of each interval in whole reference-clock ticks.

The write window is the stretch of samples in which chip select and write enable are both low. It opens at whichever of the two strobes falls last and closes at whichever rises first. The monitor checks the window's length, the stability of the address inside it and the setup time of the write data. It also checks the minimum spacing of address changes while the chip is selected. On the data bus it checks for two conditions: the host driving while the memory is driving, and the host starting to drive too soon after the memory releases the bus. Every time limit is given as a parameter in nanoseconds together with the clock period in picoseconds. Each limit becomes a tick count by rounding up.

Every rule has its own sticky flag. A shared counter records violation events and saturates at its maximum. A synchronous clear pulse resets the flags and the counter.

Top module: `sram_strobe_monitor`

## Requirements
- R1: Write-window length is the number of consecutive samples with chip select and write enable both low. When the window ends, it is flagged on `err_o[0]` if its length is below ceil(8 ns / period), which is 4 ticks at the default 2000 ps period. This holds whichever strobe closes the window.
- R2: A change of address between two consecutive samples that both lie inside the write window sets `err_o[1]`. An address change on the sample that opens the window is allowed.
- R3: When the write window closes, `err_o[2]` is set if the write data stayed unchanged for fewer than ceil(6 ns / period) consecutive samples (3 ticks) up to the last sample of the window.
- R4: When the address changes on a sample with chip select low, `err_o[3]` is set if the previous address was held for fewer than ceil(12 ns / period) samples (6 ticks).
- R5: `err_o[4]` is set in every sample where the host drives the bus while chip select and output enable are low and write enable is high.
- R6: `err_o[5]` is set when host drive rises fewer than ceil(6 ns / period) samples (3 ticks) after a rise of output enable or write enable. This includes a rise on the same sample.
- R7: Flags are sticky. A sample with `clr_i` high zeroes every flag and the counter, and this takes priority over any violation in that same sample.
- R8: `viol_cnt_o` increments by one for each sample in which any rule fires. A contention episode counts only on its first sample. The counter holds at 65535.
- R9: After reset, all flags and the counter are zero. Each sample's verdict appears one reference clock after that sample's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of flags and counter |
| cs_n_i | input | 1 | Sampled chip select, active low |
| oe_n_i | input | 1 | Sampled output enable, active low |
| we_n_i | input | 1 | Sampled write enable, active low |
| addr_i | input | ADDR_W | Sampled address bus |
| data_i | input | DATA_W | Sampled write-data bus |
| host_drive_i | input | 1 | Host is driving the data bus |
| err_o | output | 6 | Sticky rule flags: bit0 window, bit1 address, bit2 setup, bit3 cycle, bit4 contention, bit5 turnaround |
| viol_cnt_o | output | CNT_W | Saturating violation-event count |

## Verification
The bench changes the inputs one time unit after a rising edge. Those inputs are sampled at the following edge, and the flags and the count for that sample are registered on that same edge. The bench therefore reads both outputs one time unit after that edge, so every result is due exactly one clock after the sample that causes it. The expected flags and counts follow the tick arithmetic of the requirements. Each vector row places its boundary cases at that single-clock offset: windows of 2, 3 and 4 ticks, a data age of 2, an address age of 4, and turnaround gaps of 0, 1 and 3.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;

  localparam int unsigned NRULE    = 6;
  localparam int unsigned R_WIN    = 0;
  localparam int unsigned R_ADDR   = 1;
  localparam int unsigned R_SETUP  = 2;
  localparam int unsigned R_CYCLE  = 3;
  localparam int unsigned R_CONT   = 4;
  localparam int unsigned R_TURN   = 5;

  localparam int unsigned NAGE     = 4;
  localparam int unsigned A_WIN    = 0;
  localparam int unsigned A_DATA   = 1;
  localparam int unsigned A_ADDR   = 2;
  localparam int unsigned A_TURN   = 3;

  // Nanosecond limit converted to whole reference ticks, rounded up.
  function automatic int unsigned ceil_ticks(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/smon_age_cnt.sv
module smon_age_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] age
);
  // Counts samples since the last restart; saturates at all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '1;
    else if (restart)      age <= W'(1);
    else if (age != '1)    age <= age + W'(1);
  end
endmodule

// File: rtl/smon_flag_bank.sv
module smon_flag_bank #(
  parameter int unsigned NR = 6,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NR-1:0] ev,
  input  logic          cnt_ev,
  output logic [NR-1:0] flags,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      cnt   <= '0;
    end else if (clr) begin
      flags <= '0;
      cnt   <= '0;
    end else begin
      flags <= flags | ev;
      if (cnt_ev && (cnt != '1)) cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sram_strobe_monitor.sv
module sram_strobe_monitor
  import sram_mon_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_PS  = 2000,
  parameter int unsigned WP_NS   = 8,
  parameter int unsigned DS_NS   = 6,
  parameter int unsigned RC_NS   = 12,
  parameter int unsigned TURN_NS = 6,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              host_drive_i,
  output logic [NRULE-1:0]  err_o,
  output logic [CNT_W-1:0]  viol_cnt_o
);

  localparam int unsigned WP_T   = ceil_ticks(WP_NS, CLK_PS);
  localparam int unsigned DS_T   = ceil_ticks(DS_NS, CLK_PS);
  localparam int unsigned RC_T   = ceil_ticks(RC_NS, CLK_PS);
  localparam int unsigned TURN_T = ceil_ticks(TURN_NS, CLK_PS);
  localparam int unsigned MAX_T  = max4(WP_T, DS_T, RC_T, TURN_T);
  localparam int unsigned AGE_W  = $clog2(MAX_T + 1) + 1;

  // Previous sample of every watched pin.
  logic              p_cs_n, p_oe_n, p_we_n, p_drv;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cs_n <= 1'b1;
      p_oe_n <= 1'b1;
      p_we_n <= 1'b1;
      p_drv  <= 1'b0;
      p_addr <= '0;
      p_data <= '0;
    end else begin
      p_cs_n <= cs_n_i;
      p_oe_n <= oe_n_i;
      p_we_n <= we_n_i;
      p_drv  <= host_drive_i;
      p_addr <= addr_i;
      p_data <= data_i;
    end
  end

  // Edge and state events, named for the checker.
  logic win_now, win_prv, win_open, win_close;
  logic addr_chg, data_chg, strobe_rise, drv_start;
  logic cont_now, cont_prv;

  assign win_now     = !cs_n_i && !we_n_i;
  assign win_prv     = !p_cs_n && !p_we_n;
  assign win_open    = win_now && !win_prv;
  assign win_close   = win_prv && !win_now;
  assign addr_chg    = (addr_i != p_addr);
  assign data_chg    = (data_i != p_data);
  assign strobe_rise = (oe_n_i && !p_oe_n) || (we_n_i && !p_we_n);
  assign drv_start   = host_drive_i && !p_drv;
  assign cont_now    = !cs_n_i && !oe_n_i && we_n_i && host_drive_i;
  assign cont_prv    = !p_cs_n && !p_oe_n && p_we_n && p_drv;

  // Interval counters, one per measured span.
  logic [NAGE-1:0]  age_restart;
  logic [AGE_W-1:0] age_q [NAGE];

  assign age_restart[A_WIN]  = win_open;
  assign age_restart[A_DATA] = data_chg;
  assign age_restart[A_ADDR] = addr_chg;
  assign age_restart[A_TURN] = strobe_rise;

  for (genvar g = 0; g < NAGE; g++) begin : g_age
    smon_age_cnt #(.W(AGE_W)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (age_restart[g]),
      .age     (age_q[g])
    );
  end

  // Rule verdicts for the current sample.
  logic [NRULE-1:0] ev_vec;
  logic             cnt_ev;

  assign ev_vec[R_WIN]   = win_close && (age_q[A_WIN]  < AGE_W'(WP_T));
  assign ev_vec[R_ADDR]  = addr_chg && win_now && win_prv;
  assign ev_vec[R_SETUP] = win_close && (age_q[A_DATA] < AGE_W'(DS_T));
  assign ev_vec[R_CYCLE] = addr_chg && !cs_n_i && (age_q[A_ADDR] < AGE_W'(RC_T));
  assign ev_vec[R_CONT]  = cont_now;
  assign ev_vec[R_TURN]  = drv_start && (strobe_rise || (age_q[A_TURN] < AGE_W'(TURN_T)));

  assign cnt_ev = (|ev_vec[R_CYCLE:R_WIN]) || ev_vec[R_TURN] || (cont_now && !cont_prv);

  smon_flag_bank #(.NR(NRULE), .CW(CNT_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_i),
    .ev     (ev_vec),
    .cnt_ev (cnt_ev),
    .flags  (err_o),
    .cnt    (viol_cnt_o)
  );

endmodule

// File: rtl/smon_chk.sv
module smon_chk #(
  parameter int unsigned NR = 6,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic          cs_n_i,
  input logic          oe_n_i,
  input logic          we_n_i,
  input logic          host_drive_i,
  input logic [NR-1:0] ev_vec,
  input logic [NR-1:0] err_o,
  input logic [CW-1:0] viol_cnt_o
);

  p_win_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec[0] && !clr_i) |=> err_o[0]);

  p_addr_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec[1] && !clr_i) |=> err_o[1]);

  p_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && !oe_n_i && we_n_i && host_drive_i && !clr_i) |=> err_o[4]);

  p_turn_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_n_i) && $rose(host_drive_i) && !clr_i) |=> err_o[5]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((err_o & $past(err_o)) == $past(err_o)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((err_o == '0) && (viol_cnt_o == '0)));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((viol_cnt_o == $past(viol_cnt_o)) || (viol_cnt_o == $past(viol_cnt_o) + CW'(1))));

  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol_cnt_o == '1) && !clr_i) |=> (viol_cnt_o == '1));

  p_quiet_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n_i && $past(we_n_i) && !clr_i) |=> ($stable(err_o[2]) || !$past(rst_n)));

endmodule

bind sram_strobe_monitor smon_chk #(.NR(6), .CW(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_i        (clr_i),
  .cs_n_i       (cs_n_i),
  .oe_n_i       (oe_n_i),
  .we_n_i       (we_n_i),
  .host_drive_i (host_drive_i),
  .ev_vec       (ev_vec),
  .err_o        (err_o),
  .viol_cnt_o   (viol_cnt_o)
);

// File: tb/tb_sram_strobe_monitor.sv
`timescale 1ns/1ps
module tb_sram_strobe_monitor;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        cs_n_i = 1'b1, oe_n_i = 1'b1, we_n_i = 1'b1;
  logic [18:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        host_drive_i = 1'b0;
  logic [5:0]  err_o;
  logic [15:0] viol_cnt_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_monitor dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .cs_n_i(cs_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .addr_i(addr_i), .data_i(data_i), .host_drive_i(host_drive_i),
    .err_o(err_o), .viol_cnt_o(viol_cnt_o)
  );

  // Row: clr cs oe we addr[4] data[8] drv | exp_err[6] exp_cnt[8]
  // Default limits: window 4, setup 3, cycle 6, turnaround 3 ticks.
  localparam logic [30:0] VEC [30] = '{
    {1'b0,1'b1,1'b1,1'b1,4'h1,8'h00,1'b0, 6'b000000,8'd0}, // 0  R1 idle
    {1'b0,1'b0,1'b1,1'b1,4'h1,8'h00,1'b0, 6'b000000,8'd0}, // 1  R1 select
    {1'b0,1'b0,1'b1,1'b0,4'h1,8'h55,1'b1, 6'b000000,8'd0}, // 2  R1 window 1
    {1'b0,1'b0,1'b1,1'b0,4'h1,8'h55,1'b1, 6'b000000,8'd0}, // 3
    {1'b0,1'b0,1'b1,1'b0,4'h1,8'h55,1'b1, 6'b000000,8'd0}, // 4
    {1'b0,1'b0,1'b1,1'b0,4'h1,8'h55,1'b1, 6'b000000,8'd0}, // 5  window 4
    {1'b0,1'b0,1'b1,1'b1,4'h1,8'h55,1'b1, 6'b000000,8'd0}, // 6  R1 close ok
    {1'b0,1'b0,1'b1,1'b1,4'h2,8'h55,1'b1, 6'b000000,8'd0}, // 7  R4 age 7 ok
    {1'b0,1'b0,1'b1,1'b0,4'h2,8'h55,1'b1, 6'b000000,8'd0}, // 8
    {1'b0,1'b0,1'b1,1'b0,4'h2,8'h55,1'b1, 6'b000000,8'd0}, // 9
    {1'b0,1'b0,1'b1,1'b1,4'h2,8'h55,1'b1, 6'b000001,8'd1}, // 10 R1 window 2
    {1'b1,1'b0,1'b1,1'b1,4'h2,8'h55,1'b0, 6'b000000,8'd0}, // 11 R7 clear
    {1'b0,1'b0,1'b1,1'b1,4'h2,8'h55,1'b0, 6'b000000,8'd0}, // 12
    {1'b0,1'b0,1'b1,1'b0,4'h2,8'h55,1'b1, 6'b000000,8'd0}, // 13 R6 gap 3 ok
    {1'b0,1'b0,1'b1,1'b0,4'h2,8'h55,1'b1, 6'b000000,8'd0}, // 14
    {1'b0,1'b0,1'b1,1'b0,4'h2,8'hAA,1'b1, 6'b000000,8'd0}, // 15 R3 data moves
    {1'b0,1'b0,1'b1,1'b0,4'h2,8'hAA,1'b1, 6'b000000,8'd0}, // 16
    {1'b0,1'b0,1'b1,1'b1,4'h2,8'hAA,1'b1, 6'b000100,8'd1}, // 17 R3 age 2
    {1'b0,1'b0,1'b1,1'b0,4'h2,8'hAA,1'b1, 6'b000100,8'd1}, // 18
    {1'b0,1'b0,1'b1,1'b0,4'h3,8'hAA,1'b1, 6'b000110,8'd2}, // 19 R2 addr in window
    {1'b0,1'b0,1'b1,1'b0,4'h3,8'hAA,1'b1, 6'b000110,8'd2}, // 20
    {1'b0,1'b0,1'b1,1'b0,4'h3,8'hAA,1'b1, 6'b000110,8'd2}, // 21
    {1'b0,1'b0,1'b1,1'b1,4'h3,8'hAA,1'b1, 6'b000110,8'd2}, // 22 R2 close ok
    {1'b0,1'b0,1'b1,1'b1,4'h4,8'hAA,1'b0, 6'b001110,8'd3}, // 23 R4 age 4
    {1'b0,1'b0,1'b0,1'b1,4'h4,8'hAA,1'b0, 6'b001110,8'd3}, // 24
    {1'b0,1'b0,1'b0,1'b1,4'h4,8'hAA,1'b1, 6'b011110,8'd4}, // 25 R5 contention
    {1'b0,1'b0,1'b0,1'b1,4'h4,8'hAA,1'b1, 6'b011110,8'd4}, // 26 R5 counted once
    {1'b0,1'b0,1'b1,1'b1,4'h4,8'hAA,1'b0, 6'b011110,8'd4}, // 27
    {1'b0,1'b0,1'b1,1'b1,4'h4,8'hAA,1'b1, 6'b111110,8'd5}, // 28 R6 gap 1
    {1'b0,1'b1,1'b1,1'b1,4'h4,8'hAA,1'b0, 6'b111110,8'd5}  // 29
  };

  function automatic string row_req(input int i);
    if (i <= 10) return "R1";
    if (i <= 12) return "R7";
    if (i <= 17) return "R3";
    if (i <= 22) return "R2";
    if (i == 23) return "R4";
    if (i <= 26) return "R5";
    return "R6";
  endfunction

  task automatic step(input logic c, input logic cs, input logic oe, input logic we,
                      input logic [3:0] a, input logic [7:0] d, input logic drv);
    clr_i = c; cs_n_i = cs; oe_n_i = oe; we_n_i = we;
    addr_i = {15'b0, a}; data_i = d; host_drive_i = drv;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [5:0] e_err, input logic [15:0] e_cnt,
                       input string what);
    n_run++;
    if (err_o !== e_err || viol_cnt_o !== e_cnt) begin
      n_fail++;
      $display("FAIL %s %s: err=%b cnt=%0d expected err=%b cnt=%0d",
               req, what, err_o, viol_cnt_o, e_err, e_cnt);
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", 6'b0, 16'd0, "during reset");
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00, 1'b0);
    check("R9", 6'b0, 16'd0, "after reset");

    for (int i = 0; i < 30; i++) begin
      step(VEC[i][30], VEC[i][29], VEC[i][28], VEC[i][27],
           VEC[i][26:23], VEC[i][22:15], VEC[i][14]);
      check(row_req(i), VEC[i][13:8], {8'd0, VEC[i][7:0]}, $sformatf("row %0d", i));
    end

    // R1: chip-select-controlled window of 3 ticks.
    step(1'b1, 1'b1, 1'b1, 1'b1, 4'h4, 8'hAA, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'h4, 8'hAA, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'h4, 8'hAA, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'h4, 8'hAA, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'h4, 8'hAA, 1'b0);
    check("R1", 6'b0, 16'd0, "cs window still open");
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'h4, 8'hAA, 1'b0);
    check("R1", 6'b000001, 16'd1, "cs-closed window of 3");

    // R6: host drive rising on the very sample output enable rises.
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'h4, 8'hAA, 1'b1);
    check("R6", 6'b100000, 16'd1, "zero-gap turnaround");

    // R7: clear wins over a contention start in the same sample.
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b1);
    check("R7", 6'b0, 16'd0, "clear beats contention");
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b1);
    check("R5", 6'b010000, 16'd0, "contention continues uncounted");

    // R8: repeated contention episodes, then saturation.
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b0);
    for (int k = 0; k < 100; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b0);
    end
    check("R8", 6'b010000, 16'd100, "100 episodes");
    for (int k = 0; k < 65440; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1, 4'h4, 8'hAA, 1'b0);
    end
    check("R8", 6'b010000, 16'hFFFF, "saturated count");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule